// File: doc/BRIEF.md
# Video Memory Byte-Write Arbiter

This block sits between a CPU bus and three on-chip video stores: a tile/bitmap RAM, a palette RAM and a sprite attribute RAM. Each request names its target store, an access size of 8, 16 or 32 bits and a byte offset. The block folds the offset into the physical range of the selected store, and it applies the byte-write rules of each store. It then drives an aligned, byte-enabled word access into a synchronous RAM. Reads come back zero-extended and little-endian one cycle after the request.

A byte write never reaches a store as a single byte. On the palette store, and on the low part of the tile store, the byte is copied into both bytes of the enclosing halfword. On the sprite attribute store, and in the sprite part of the tile store, the byte write is dropped. The display mode input sets where that sprite part starts. A registered output always carries palette halfword 0, which is the backdrop colour.

The tile window is 2^TILE_AW bytes, and the tile store fills three quarters of it. Offsets in the top quarter fold onto the quarter below it. With TILE_AW = 17 this gives the 96 KiB store in a 128 KiB window. The default TILE_AW = 12 gives a 3 KiB store in a 4 KiB window, and the requirement values below use that default. The palette and attribute stores are 2^PAL_AW bytes each (default 1 KiB).

Top module: `vm_bytewr_arbiter`

## Requirements
- R1: After reset every store reads as zero, `backdrop` is 0 and `rsp_valid` is low.
- R2: A read request (`req_valid` high, `req_we` low) raises `rsp_valid` for exactly one cycle, in the cycle that follows it. Write requests never raise `rsp_valid`.
- R3: `req_size` is coded 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. Data is little-endian: byte k of a word sits on bits 8k+7:8k. A halfword access ignores offset bit 0 and a word access ignores bits 1:0. A read result is zero-extended in `rsp_rdata`.
- R4: On the tile store, an offset at or above 0xC00 (3/4 of the window) maps to 0x800 plus its low 10 bits (low TILE_AW-2 bits). Lower offsets are used as they are.
- R5: The palette and attribute stores use only the low PAL_AW bits of the offset (mask 0x3FF), so offset 0x402 reaches 0x002.
- R6: A palette byte write of value v stores v into both bytes of the halfword at the offset with bit 0 cleared. The other halfword of the word is not changed.
- R7: A tile byte write below the sprite boundary also writes v into both bytes of the aligned halfword.
- R8: In display modes 0, 1 and 2 the sprite boundary is 0x800 (half the window). In any other mode it is 0xA00 (half plus one eighth). A tile byte write whose folded offset is at or above the boundary changes nothing. Halfword and word writes there proceed normally.
- R9: Every byte write to the attribute store is ignored. Halfword and word writes to it proceed normally.
- R10: `backdrop` equals palette halfword 0. It takes a new value in the cycle after a write that touches palette bytes 0 or 1, and it holds through all other activity.
- R11: `req_target` is coded 0 = tile, 1 = palette, 2 = attribute, 3 = none. A write to target 3 changes nothing, and a read from it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears state and all stores |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_target | input | 2 | Store select (R11 coding) |
| req_size | input | 2 | Access size (R3 coding) |
| req_addr | input | TILE_AW | Byte offset inside the target window |
| req_wdata | input | 32 | Write data, right-aligned for byte and halfword |
| disp_mode | input | 3 | Current display mode, sets the sprite boundary |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Zero-extended read data |
| backdrop | output | 16 | Palette halfword 0 |

## Verification
Word, halfword and byte reads of one known word show that lane selection is correct and that the low offset bits are ignored. Writes through folded and unfolded tile offsets, followed by reads through the other alias, separate a correct fold from a plain mask. Byte writes are placed on each side of the sprite boundary under modes 2 and 3, and through a folded alias. These show whether the boundary follows the mode and whether the check uses the folded offset. Byte writes to the palette and attribute stores, read back as words, show duplication versus dropping. The backdrop output is checked after writes to both lanes of palette word 0 and after a write to its upper halfword.

// File: rtl/vm_pkg.sv
package vm_pkg;

    typedef enum logic [1:0] {
        TGT_TILE = 2'd0,
        TGT_PAL  = 2'd1,
        TGT_ATTR = 2'd2,
        TGT_NONE = 2'd3
    } vm_target_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } vm_size_e;

    typedef struct packed {
        logic        rsp_valid;
        logic [1:0]  target;
        logic [1:0]  size;
        logic [1:0]  lane;
        logic [15:0] backdrop;
    } vm_state_t;

    // Pick the addressed lanes out of a stored word and zero-extend them.
    function automatic logic [31:0] lane_extract(input logic [31:0] word,
                                                 input logic [1:0]  size,
                                                 input logic [1:0]  lane);
        logic [31:0] res;
        case (size)
            SZ_BYTE: res = {24'd0, word[8*lane +: 8]};
            SZ_HALF: res = {16'd0, word[16*lane[1] +: 16]};
            default: res = word;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/vm_addr_map.sv
module vm_addr_map
    import vm_pkg::*;
#(
    parameter int TILE_AW = 12,
    parameter int PAL_AW  = 10
) (
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [1:0]         req_target,
    input  logic [1:0]         req_size,
    input  logic [TILE_AW-1:0] req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [2:0]         disp_mode,
    output logic [TILE_AW-3:0] tile_idx,
    output logic [PAL_AW-3:0]  pal_idx,
    output logic [1:0]         lane,
    output logic               wr_en,
    output logic [3:0]         wr_be,
    output logic [31:0]        wr_data
);

    localparam int unsigned HALF_I = 1 << (TILE_AW - 1);
    localparam int unsigned MIRR_I = 3 << (TILE_AW - 2);
    localparam int unsigned ALT_I  = HALF_I + (1 << (TILE_AW - 3));

    localparam logic [TILE_AW-1:0] HALF_WIN  = TILE_AW'(HALF_I);
    localparam logic [TILE_AW-1:0] MIRR_BASE = TILE_AW'(MIRR_I);
    localparam logic [TILE_AW-1:0] ALT_SPR   = TILE_AW'(ALT_I);

    logic [TILE_AW-1:0] tile_off;
    logic [PAL_AW-1:0]  pal_off;
    logic [TILE_AW-1:0] spr_base;
    logic [3:0]         half_be;
    logic               allow;

    always_comb begin
        // fold the top quarter of the window onto the quarter below it
        if (req_addr >= MIRR_BASE)
            tile_off = HALF_WIN | {2'b00, req_addr[TILE_AW-3:0]};
        else
            tile_off = req_addr;
        pal_off  = req_addr[PAL_AW-1:0];
        spr_base = (disp_mode <= 3'd2) ? HALF_WIN : ALT_SPR;
        lane     = (req_target == TGT_TILE) ? tile_off[1:0] : pal_off[1:0];
        half_be  = lane[1] ? 4'b1100 : 4'b0011;

        case (req_size)
            SZ_BYTE: begin
                wr_be   = half_be;
                wr_data = {4{req_wdata[7:0]}};
                allow   = ((req_target == TGT_TILE) && (tile_off < spr_base)) ||
                          (req_target == TGT_PAL);
            end
            SZ_HALF: begin
                wr_be   = half_be;
                wr_data = {2{req_wdata[15:0]}};
                allow   = (req_target != TGT_NONE);
            end
            default: begin
                wr_be   = 4'b1111;
                wr_data = req_wdata;
                allow   = (req_target != TGT_NONE);
            end
        endcase

        wr_en    = req_valid && req_we && allow;
        tile_idx = tile_off[TILE_AW-1:2];
        pal_idx  = pal_off[PAL_AW-1:2];
    end

endmodule

// File: rtl/vm_word_ram.sv
module vm_word_ram #(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [3:0]       wr_be,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data
);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] mem [DEPTH];
        logic [7:0] rd_b_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= 8'd0;
                rd_b_q <= 8'd0;
            end else begin
                if (wr_en && wr_be[g]) mem[idx] <= wr_data[8*g +: 8];
                if (rd_en) rd_b_q <= mem[idx];
            end
        end

        assign rd_data[8*g +: 8] = rd_b_q;
    end

endmodule

// File: rtl/vm_bytewr_arbiter.sv
module vm_bytewr_arbiter
    import vm_pkg::*;
#(
    parameter int TILE_AW = 12,
    parameter int PAL_AW  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [1:0]         req_target,
    input  logic [1:0]         req_size,
    input  logic [TILE_AW-1:0] req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [2:0]         disp_mode,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [15:0]        backdrop
);

    localparam int TILE_DEPTH = 3 << (TILE_AW - 4);
    localparam int PAL_DEPTH  = 1 << (PAL_AW - 2);
    localparam int LOW_WORDS  = 1 << (TILE_AW - 3);

    logic [TILE_AW-3:0] tile_idx;
    logic [PAL_AW-3:0]  pal_idx;
    logic [1:0]         lane;
    logic               wr_en;
    logic [3:0]         wr_be;
    logic [31:0]        wr_data;
    logic               is_rd;
    logic               tile_we, pal_we, attr_we;
    logic [31:0]        tile_rd, pal_rd, attr_rd;
    logic [31:0]        sel_word;
    vm_state_t          st_d, st_q;

    vm_addr_map #(.TILE_AW(TILE_AW), .PAL_AW(PAL_AW)) u_map (
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_target(req_target),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .disp_mode (disp_mode),
        .tile_idx  (tile_idx),
        .pal_idx   (pal_idx),
        .lane      (lane),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data)
    );

    assign is_rd   = req_valid && !req_we;
    assign tile_we = wr_en && (req_target == TGT_TILE);
    assign pal_we  = wr_en && (req_target == TGT_PAL);
    assign attr_we = wr_en && (req_target == TGT_ATTR);

    vm_word_ram #(.DEPTH(TILE_DEPTH), .IDX_W(TILE_AW-2)) u_tile (
        .clk(clk), .rst_n(rst_n),
        .rd_en(is_rd && (req_target == TGT_TILE)), .wr_en(tile_we),
        .wr_be(wr_be), .idx(tile_idx), .wr_data(wr_data), .rd_data(tile_rd)
    );

    vm_word_ram #(.DEPTH(PAL_DEPTH), .IDX_W(PAL_AW-2)) u_pal (
        .clk(clk), .rst_n(rst_n),
        .rd_en(is_rd && (req_target == TGT_PAL)), .wr_en(pal_we),
        .wr_be(wr_be), .idx(pal_idx), .wr_data(wr_data), .rd_data(pal_rd)
    );

    vm_word_ram #(.DEPTH(PAL_DEPTH), .IDX_W(PAL_AW-2)) u_attr (
        .clk(clk), .rst_n(rst_n),
        .rd_en(is_rd && (req_target == TGT_ATTR)), .wr_en(attr_we),
        .wr_be(wr_be), .idx(pal_idx), .wr_data(wr_data), .rd_data(attr_rd)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = is_rd;
        if (is_rd) begin
            st_d.target = req_target;
            st_d.size   = req_size;
            st_d.lane   = lane;
        end
        // keep a shadow of palette halfword 0 for the backdrop port
        if (pal_we && (pal_idx == '0)) begin
            if (wr_be[0]) st_d.backdrop[7:0]  = wr_data[7:0];
            if (wr_be[1]) st_d.backdrop[15:8] = wr_data[15:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.target)
            TGT_TILE: sel_word = tile_rd;
            TGT_PAL:  sel_word = pal_rd;
            TGT_ATTR: sel_word = attr_rd;
            default:  sel_word = 32'd0;
        endcase
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = lane_extract(sel_word, st_q.size, st_q.lane);
    assign backdrop  = st_q.backdrop;

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rsp_valid);

    p_write_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we) |=> !rsp_valid);

    p_lane_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be == 4'b0011 || wr_be == 4'b1100 || wr_be == 4'b1111));

    p_tile_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tile_we |-> (int'(tile_idx) < TILE_DEPTH));

    p_byte_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_size == SZ_BYTE) |-> (wr_data[15:8] == wr_data[7:0] && wr_be != 4'b1111));

    p_sprite_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_we && req_size == SZ_BYTE && disp_mode <= 3'd2) |-> (int'(tile_idx) < LOW_WORDS));

    p_attr_byte_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_we && req_target == TGT_ATTR && req_size == SZ_BYTE) |-> !attr_we);

    p_backdrop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pal_we && pal_idx == '0) |=> $stable(backdrop));

    p_none_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_target == TGT_NONE) |-> !wr_en);

endmodule

// File: tb/vm_bytewr_arbiter_tb.sv
`timescale 1ns/1ps
module vm_bytewr_arbiter_tb;

    localparam int TILE_AW = 12;
    localparam int PAL_AW  = 10;
    localparam logic [1:0] T_TILE = 2'd0, T_PAL = 2'd1, T_ATTR = 2'd2, T_NONE = 2'd3;
    localparam logic [1:0] S_B = 2'd0, S_H = 2'd1, S_W = 2'd2, S_W3 = 2'd3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_we = 1'b0;
    logic [1:0]         req_target = '0;
    logic [1:0]         req_size = '0;
    logic [TILE_AW-1:0] req_addr = '0;
    logic [31:0]        req_wdata = '0;
    logic [2:0]         disp_mode = '0;
    logic               rsp_valid;
    logic [31:0]        rsp_rdata;
    logic [15:0]        backdrop;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    vm_bytewr_arbiter #(.TILE_AW(TILE_AW), .PAL_AW(PAL_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_target(req_target), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .disp_mode(disp_mode), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .backdrop(backdrop)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] tgt, input logic [1:0] sz,
                      input logic [TILE_AW-1:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_target = tgt;
        req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] tgt, input logic [1:0] sz,
                      input logic [TILE_AW-1:0] a, input logic [31:0] exp, input string tag);
        req_valid = 1'b1; req_we = 1'b0; req_target = tgt;
        req_size = sz; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: every response pops one expected item
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        checks++; fails++;
        $display("FAIL R2 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 backdrop in reset", {16'd0, backdrop}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        rd(T_TILE, S_W, 12'h000, 32'h0, "R1 tile zero");
        rd(T_PAL,  S_W, 12'h3FC, 32'h0, "R1 palette zero");
        rd(T_ATTR, S_W, 12'h100, 32'h0, "R1 attr zero");
        @(negedge clk);
        check("R2 single-cycle rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // R3 sizes and lanes
        wr(T_TILE, S_W, 12'h010, 32'h44332211);
        check("R2 no response to write", {31'd0, rsp_valid}, 32'd0);
        rd(T_TILE, S_W, 12'h010, 32'h44332211, "R3 word");
        rd(T_TILE, S_B, 12'h012, 32'h00000033, "R3 byte lane 2");
        rd(T_TILE, S_B, 12'h013, 32'h00000044, "R3 byte lane 3");
        rd(T_TILE, S_H, 12'h013, 32'h00004433, "R3 half ignores bit0");
        rd(T_TILE, S_W, 12'h013, 32'h44332211, "R3 word ignores bits1:0");
        wr(T_TILE, S_W3, 12'h060, 32'h01020304);
        rd(T_TILE, S_W, 12'h060, 32'h01020304, "R3 size 3 as word");

        // R4 folding of the tile window
        wr(T_TILE, S_W, 12'hC40, 32'hCAFEF00D);
        rd(T_TILE, S_W, 12'h840, 32'hCAFEF00D, "R4 fold write");
        wr(T_TILE, S_W, 12'hB40, 32'h00000005);
        rd(T_TILE, S_W, 12'hF40, 32'h00000005, "R4 fold read");
        wr(T_TILE, S_W, 12'hBFC, 32'h00000077);
        rd(T_TILE, S_W, 12'hFFC, 32'h00000077, "R4 fold top edge");
        rd(T_TILE, S_W, 12'hBFC, 32'h00000077, "R4 unfolded edge");

        // R6 and R5 palette
        wr(T_PAL, S_B, 12'h005, 32'h000000AB);
        rd(T_PAL, S_W, 12'h004, 32'h0000ABAB, "R6 palette byte dup");
        wr(T_PAL, S_H, 12'h402, 32'h00001234);
        check("R10 backdrop untouched by upper half", {16'd0, backdrop}, 32'h0);
        rd(T_PAL, S_H, 12'h002, 32'h00001234, "R5 palette mask");
        wr(T_PAL, S_H, 12'h400, 32'h00007FFF);
        check("R10 backdrop half write", {16'd0, backdrop}, 32'h7FFF);
        wr(T_PAL, S_B, 12'h001, 32'h0000001F);
        check("R10 backdrop byte write", {16'd0, backdrop}, 32'h1F1F);
        rd(T_PAL, S_W, 12'h000, 32'h12341F1F, "R6 palette byte keeps other half");
        wr(T_PAL, S_W, 12'h000, 32'hDEAD0123);
        check("R10 backdrop word write", {16'd0, backdrop}, 32'h0123);
        wr(T_PAL, S_B, 12'h003, 32'h00000077);
        check("R10 backdrop holds", {16'd0, backdrop}, 32'h0123);
        rd(T_PAL, S_W, 12'h000, 32'h77770123, "R6 palette upper byte dup");

        // R7 tile byte duplication
        disp_mode = 3'd0;
        wr(T_TILE, S_B, 12'h021, 32'h0000005A);
        rd(T_TILE, S_W, 12'h020, 32'h00005A5A, "R7 tile byte dup");

        // R8 sprite boundary
        wr(T_TILE, S_W, 12'h800, 32'h11111111);
        wr(T_TILE, S_B, 12'h802, 32'h000000EE);
        rd(T_TILE, S_W, 12'h800, 32'h11111111, "R8 mode0 drop at 0x800");
        wr(T_TILE, S_B, 12'h7FF, 32'h00000099);
        rd(T_TILE, S_W, 12'h7FC, 32'h99990000, "R8 mode0 accept below");
        disp_mode = 3'd3;
        wr(T_TILE, S_B, 12'h802, 32'h000000EE);
        rd(T_TILE, S_W, 12'h800, 32'hEEEE1111, "R8 mode3 accept 0x802");
        wr(T_TILE, S_B, 12'hC02, 32'h00000033);
        rd(T_TILE, S_W, 12'h800, 32'h33331111, "R8 folded byte accepted");
        wr(T_TILE, S_W, 12'hA00, 32'h22222222);
        wr(T_TILE, S_B, 12'hA01, 32'h00000044);
        rd(T_TILE, S_W, 12'hA00, 32'h22222222, "R8 mode3 drop at 0xA00");
        wr(T_TILE, S_B, 12'h9FF, 32'h00000066);
        rd(T_TILE, S_W, 12'h9FC, 32'h66660000, "R8 mode3 accept below 0xA00");
        disp_mode = 3'd2;
        wr(T_TILE, S_B, 12'h900, 32'h00000055);
        rd(T_TILE, S_W, 12'h900, 32'h00000000, "R8 mode2 drop");

        // R9 attribute store
        wr(T_ATTR, S_W, 12'h100, 32'hA5A5A5A5);
        wr(T_ATTR, S_B, 12'h101, 32'h00000000);
        wr(T_ATTR, S_B, 12'h102, 32'h00000000);
        rd(T_ATTR, S_W, 12'h100, 32'hA5A5A5A5, "R9 attr byte ignored");
        wr(T_ATTR, S_H, 12'h102, 32'h00000BAD);
        rd(T_ATTR, S_W, 12'h500, 32'h0BADA5A5, "R9 attr half write");
        rd(T_ATTR, S_H, 12'h103, 32'h00000BAD, "R5 attr mask half read");

        // R11 no target
        wr(T_NONE, S_W, 12'h010, 32'hFFFFFFFF);
        rd(T_NONE, S_W, 12'h010, 32'h00000000, "R11 none reads zero");
        rd(T_TILE, S_W, 12'h010, 32'h44332211, "R11 none write ignored");
        rd(T_PAL,  S_W, 12'h010, 32'h00000000, "R11 palette untouched");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2 missing responses actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule